// File: doc/BRIEF.md
# Dual-Mode Program/Run Byte Memory

This block is the only memory of a small accumulator-style processor. It holds sixteen bytes, and the program and its working data both live in them. Any location can be reached directly through a 4-bit address, in any order. The address comes from outside the block.

A single mode input decides where writes come from.

- **Program mode (mode low):** an operator loads the memory by hand. An 8-bit switch value is stored when an active-low write button is pressed. The button is not debounced. It passes through a two-flop synchroniser, and every clock cycle in which the synchronised button reads low stores the switch value again.
- **Run mode (mode high):** the processor stores the byte on the shared data bus. The write happens at the rising clock edge, and only if the load control is high at that edge.

The addressed byte is always readable, in true polarity, on a display output, whether or not the bus is being driven. A read-enable places the same byte on the bus-side output together with an output-enable. Bus arbitration, the address register and the switch hardware stay outside the block.

Top module: `dual_mode_mem`

## Requirements
- R1: While reset is high and after it is released, every location reads 0x00, and `bus_oe` is low while `rd_en` is low.
- R2: In run mode (`mode_run`=1), when `load` is high at a rising clock edge, `bus_in` is stored at `addr`. The new byte shows on `disp_data` right after that edge.
- R3: In run mode, a rising edge with `load` low changes no location.
- R4: In program mode (`mode_run`=0), after `wr_btn_n` goes low, `sw_data` is stored at `addr` at the third rising edge, not earlier. The button passes through a two-flop synchroniser first.
- R5: While the button is held in program mode, the same byte is stored at every edge. The final content after release is the switch value.
- R6: In run mode, the write button has no effect on any location.
- R7: In program mode, `load` and `bus_in` have no effect on any location.
- R8: `disp_data` shows the byte at the current `addr` within the same cycle, with no clock edge needed, after `addr` changes.
- R9: `bus_oe` equals `rd_en`. While `rd_en` is high, `bus_out` equals `disp_data`. While it is low, `bus_out` is 0x00.
- R10: A byte reads back exactly as it was written, with no bit inverted. This holds even though the internal cells store the complement.
- R11: The sixteen locations are independent: a write to one address leaves the other fifteen unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_run | input | 1 | 0 = program mode, 1 = run mode |
| addr | input | 4 | Location selected for read and write |
| sw_data | input | 8 | Switch byte written in program mode |
| wr_btn_n | input | 1 | Manual write button, active low, asynchronous |
| bus_in | input | 8 | Data bus byte written in run mode |
| load | input | 1 | Run-mode write request |
| rd_en | input | 1 | Drives the stored byte toward the bus |
| bus_out | output | 8 | Byte for the bus; 0x00 when not enabled |
| bus_oe | output | 1 | Tri-state enable for the bus driver |
| disp_data | output | 8 | Always-valid byte at the current address |

## Verification
The bench runs directed sequences and seeded random ones. These mix run-mode writes with `load` high and low, button presses of several hold lengths, and read-enable toggles.

- **Three-edge button latency:** a press is checked one edge before and one edge after the write should land. This separates a correct two-flop synchroniser from a missing stage or an extra one.
- **Cross-mode stimulus:** the button is pressed in run mode, and `load` is raised in program mode. Both should leave memory unchanged, which exposes a mode select that fails to gate the strobe.
- **Address sweep:** sixteen distinct bytes are written and then read back with changing addresses. This catches address aliasing, inverted storage polarity and a registered read path.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic {
        MODE_PROG = 1'b0,
        MODE_RUN  = 1'b1
    } mode_e;

    typedef struct packed {
        logic  en;
        addr_t addr;
        byte_t data;
    } wr_req_t;

    // Converts between bus polarity and cell polarity (self-inverse).
    function automatic byte_t cell_polarity(byte_t v, bit inv);
        return inv ? ~v : v;
    endfunction
endpackage

// File: rtl/button_sync.sv
module button_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_n,
    output logic btn_sync_n
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= btn_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], btn_n};
            end
        end
    endgenerate

    assign btn_sync_n = chain[STAGES-1];

    // R4
    sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(btn_sync_n) |-> !$past(btn_n, STAGES));
endmodule

// File: rtl/write_source_mux.sv
module write_source_mux
    import pmem_pkg::*;
(
    input  mode_e   mode,
    input  addr_t   addr,
    input  byte_t   sw_data,
    input  logic    btn_sync_n,
    input  byte_t   bus_in,
    input  logic    load,
    output wr_req_t req
);
    always_comb begin
        req.addr = addr;
        unique case (mode)
            MODE_RUN: begin
                req.en   = load;
                req.data = bus_in;
            end
            default: begin
                req.en   = ~btn_sync_n;
                req.data = sw_data;
            end
        endcase
    end
endmodule

// File: rtl/byte_store.sv
module byte_store
    import pmem_pkg::*;
#(
    parameter bit INVERT_CELLS = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    input  addr_t   raddr,
    output byte_t   rdata
);
    byte_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= cell_polarity('0, INVERT_CELLS);
        end else if (req.en) begin
            cells[req.addr] <= cell_polarity(req.data, INVERT_CELLS);
        end
    end

    assign rdata = cell_polarity(cells[raddr], INVERT_CELLS);
endmodule

// File: rtl/dual_mode_mem.sv
module dual_mode_mem
    import pmem_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter bit          INVERT_CELLS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_run,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] sw_data,
    input  logic              wr_btn_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              load,
    input  logic              rd_en,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] disp_data
);
    logic    btn_sync_n;
    wr_req_t req;
    byte_t   rd_byte;
    mode_e   mode;

    assign mode = mode_e'(mode_run);

    button_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .btn_n      (wr_btn_n),
        .btn_sync_n (btn_sync_n)
    );

    write_source_mux u_mux (
        .mode       (mode),
        .addr       (addr),
        .sw_data    (sw_data),
        .btn_sync_n (btn_sync_n),
        .bus_in     (bus_in),
        .load       (load),
        .req        (req)
    );

    byte_store #(.INVERT_CELLS(INVERT_CELLS)) u_store (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .raddr (addr),
        .rdata (rd_byte)
    );

    assign disp_data = rd_byte;
    assign bus_oe    = rd_en;
    assign bus_out   = rd_en ? rd_byte : '0;

    // R2
    run_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_run && load) |=> (addr != $past(addr)) || (disp_data == $past(bus_in)));

    // R3 R6
    run_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_run && !load) |=> (addr != $past(addr)) || $stable(disp_data));

    // R7
    prog_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_run && btn_sync_n) |=> (addr != $past(addr)) || $stable(disp_data));

    // R9
    bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (!bus_oe && bus_out == '0));
endmodule

// File: tb/tb_dual_mode_mem.sv
module tb_dual_mode_mem;
    logic       clk = 1'b0;
    logic       rst;
    logic       mode_run;
    logic [3:0] addr;
    logic [7:0] sw_data;
    logic       wr_btn_n;
    logic [7:0] bus_in;
    logic       load;
    logic       rd_en;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [7:0] disp_data;

    int total = 0;
    int bad   = 0;
    logic [7:0] model [16];

    always #4 clk = ~clk;

    dual_mode_mem dut (
        .clk(clk), .rst(rst), .mode_run(mode_run), .addr(addr),
        .sw_data(sw_data), .wr_btn_n(wr_btn_n), .bus_in(bus_in),
        .load(load), .rd_en(rd_en), .bus_out(bus_out), .bus_oe(bus_oe),
        .disp_data(disp_data)
    );

    function automatic logic [7:0] exp_bus(logic en, logic [7:0] v);
        return en ? v : 8'h00;
    endfunction

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_loc(string req, logic [3:0] a);
        addr = a;
        #1;
        check(req, {1'b0, disp_data}, {1'b0, model[a]});
    endtask

    task automatic run_write(logic [3:0] a, logic [7:0] d, logic ld);
        @(negedge clk);
        mode_run = 1'b1; addr = a; bus_in = d; load = ld;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        if (ld) model[a] = d;
        #1;
        check(ld ? "R2" : "R3", {1'b0, disp_data}, {1'b0, model[a]});
    endtask

    task automatic prog_write(logic [3:0] a, logic [7:0] d, int hold, bit timing);
        @(negedge clk);
        mode_run = 1'b0; addr = a; sw_data = d; wr_btn_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        if (timing) check("R4", {1'b0, disp_data}, {1'b0, model[a]});
        @(posedge clk);
        @(negedge clk);
        if (timing) check("R4", {1'b0, disp_data}, {1'b0, d});
        repeat (hold) @(posedge clk);
        @(negedge clk);
        wr_btn_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model[a] = d;
        #1;
        check("R5", {1'b0, disp_data}, {1'b0, model[a]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; mode_run = 1'b0; addr = '0; sw_data = '0; wr_btn_n = 1'b1;
        bus_in = '0; load = 1'b0; rd_en = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {1'b0, disp_data}, 9'h000);
        check("R1", {bus_oe, bus_out}, 9'h000);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) check_loc("R1", i[3:0]);

        // R2 R3 run-mode writes with and without load
        run_write(4'd3, 8'hA5, 1'b1);
        run_write(4'd3, 8'h11, 1'b0);
        run_write(4'd7, 8'hFF, 1'b1);

        // R10 polarity: walking patterns come back identical
        run_write(4'd9, 8'h01, 1'b1);
        check("R10", {1'b0, disp_data}, 9'h001);
        run_write(4'd9, 8'h80, 1'b1);
        check("R10", {1'b0, disp_data}, 9'h080);

        // R4 timing and R5 hold
        prog_write(4'd12, 8'h3C, 0, 1'b1);
        prog_write(4'd12, 8'hC3, 6, 1'b1);

        // R6 button pressed in run mode
        @(negedge clk);
        mode_run = 1'b1; addr = 4'd5; sw_data = 8'h99; load = 1'b0; wr_btn_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        wr_btn_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R6", {1'b0, disp_data}, {1'b0, model[5]});

        // R7 load in program mode
        @(negedge clk);
        mode_run = 1'b0; addr = 4'd7; bus_in = 8'h42; load = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        #1;
        check("R7", {1'b0, disp_data}, {1'b0, model[7]});

        // R11 sweep: distinct bytes everywhere, then read all
        for (int i = 0; i < 16; i++) run_write(i[3:0], 8'(i * 17 + 5), 1'b1);
        for (int i = 0; i < 16; i++) check_loc("R11", i[3:0]);

        // R8 R9 asynchronous read and bus enable
        @(negedge clk);
        rd_en = 1'b1; addr = 4'd2;
        #1;
        check("R8", {1'b0, disp_data}, {1'b0, model[2]});
        check("R9", {bus_oe, bus_out}, {1'b1, model[2]});
        addr = 4'd14;
        #1;
        check("R8", {1'b0, disp_data}, {1'b0, model[14]});
        rd_en = 1'b0;
        #1;
        check("R9", {bus_oe, bus_out}, 9'h000);

        // Random mix
        for (int n = 0; n < 150; n++) begin
            int op;
            logic [3:0] a;
            logic [7:0] d;
            op = $urandom_range(0, 3);
            a  = 4'($urandom_range(0, 15));
            d  = 8'($urandom_range(0, 255));
            case (op)
                0: run_write(a, d, 1'b1);
                1: run_write(a, d, 1'b0);
                2: prog_write(a, d, $urandom_range(0, 3), 1'b0);
                default: begin
                    @(negedge clk);
                    rd_en = 1'($urandom_range(0, 1));
                    addr = a;
                    #1;
                    check("R9", {bus_oe, bus_out}, {rd_en, exp_bus(rd_en, model[a])});
                    check("R8", {1'b0, disp_data}, {1'b0, model[a]});
                end
            endcase
        end
        rd_en = 1'b0;
        for (int i = 0; i < 16; i++) check_loc("R11", i[3:0]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule